// File: doc/BRIEF.md
# JTAG Master Scan Sequencer

This block is the host side of a four-wire boundary-scan link. It runs on a system clock and derives the test clock from it. It drives the mode-select and serial-data outputs to the target and samples the target's serial return line. A client hands it one command at a time over a valid/ready handshake. The command either forces the target's test access port into its reset state, or performs an instruction scan, or performs a data scan.

Each command walks the access port's state machine without help from the client. For a scan, the walk goes from Run-Test/Idle through the capture and shift states and the update state, then back to Run-Test/Idle. Every bit shifted out is paired with a bit captured from the return line. So each write also returns the register contents that the write replaced, and these come back with the completion pulse. Between commands the test clock rests low and the target is left in Run-Test/Idle.

Top module: `jtag_scan_master`

## Requirements
- R1: While reset is high and on the first cycle after it, `tck`, `tms`, `tdi`, `busy` and `rsp_valid` are 0 and `cmd_ready` is 1.
- R2: While busy, `tck` spends H system cycles low and then H cycles high, where H is the `half_period` value latched when the command is accepted (a value of 0 acts as 1). While not busy, `tck` stays low.
- R3: `tms` and `tdi` never change while `tck` is high. They change only on the system edge that lowers `tck` or on the edge that accepts a command.
- R4: A reset command (`cmd_op` 0, and code 3 behaves the same way) produces six test-clock cycles. `tms` is 1 on the first five and 0 on the sixth, which leaves any target in Run-Test/Idle.
- R5: A data scan (`cmd_op` 2) produces 37 test-clock cycles with `tms` sequence 1,0,0, then 32 shift cycles with `tms`=1 only on the last one, then 1,0.
- R6: An instruction scan (`cmd_op` 1) produces 11 test-clock cycles with `tms` sequence 1,1,0,0, then 5 shift cycles with `tms`=1 only on the last one, then 1,0.
- R7: On shift cycle k (counting from 0), `tdi` carries `cmd_wdata[k]`, so the data is sent least significant bit first. After the scan, the target register holds the low 5 bits (instruction) or all 32 bits (data) of `cmd_wdata`.
- R8: `tdo` is sampled at each rising `tck` of a shift cycle, and the sample for shift cycle k goes to `rsp_rdata[k]`. For an instruction scan bits 31:5 read 0. After a reset command all bits read 0.
- R9: A command is accepted only when `cmd_valid` and `cmd_ready` are both 1, and `cmd_ready` equals the inverse of `busy`. A command offered while busy is ignored and causes no test-clock edges and no completion. `busy` stays high from acceptance until `rsp_valid` pulses for exactly one cycle, in the cycle `busy` drops.
- R10: `rsp_valid` rises exactly 2·H·N system cycles after the accepting edge, where N is the command's test-clock count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| half_period | input | HALF_W | System cycles per test-clock half period, latched at acceptance |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Block can accept a command |
| cmd_op | input | 2 | 0 = reset port, 1 = instruction scan, 2 = data scan, 3 = reset port |
| cmd_wdata | input | DR_LEN | Bits to shift into the target, LSB first |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | DR_LEN | Bits captured from the target, LSB first |
| busy | output | 1 | Command in progress |
| tck | output | 1 | Test clock to the target |
| tms | output | 1 | Mode select to the target |
| tdi | output | 1 | Serial data to the target |
| tdo | input | 1 | Serial data from the target |

## Verification
The bench builds the block with its default widths: 5-bit instructions, 32-bit data, a 4-bit half-period field and five reset ones. It drives half periods drawn from the whole range 0 to 15, so the zero-as-one case, the one-cycle case and long phases are all covered. A behavioural access-port model on the pins starts in a pause state, which shows that a reset command recovers from an arbitrary state. The model also makes each scan's returned word depend on the previous scan, so a shifted or reversed bit order shows up as a data mismatch.

// File: rtl/jtm_pkg.sv
package jtm_pkg;

    typedef enum logic [1:0] {
        OP_TAP_RESET  = 2'd0,
        OP_INSTR      = 2'd1,
        OP_DATA       = 2'd2,
        OP_TAP_RESET2 = 2'd3
    } jtm_op_e;

    // Per-test-clock-cycle decode of the walk
    typedef struct packed {
        logic tms;
        logic shift;
        logic last;
    } jtm_step_t;

    // Number of navigation cycles ahead of the first shift cycle
    function automatic int lead_len(jtm_op_e op);
        case (op)
            OP_INSTR: return 4;
            OP_DATA:  return 3;
            default:  return 0;
        endcase
    endfunction

    function automatic int body_len(jtm_op_e op, int ir_len, int dr_len, int ones);
        case (op)
            OP_INSTR: return ir_len;
            OP_DATA:  return dr_len;
            default:  return ones;
        endcase
    endfunction

    function automatic int step_count(jtm_op_e op, int ir_len, int dr_len, int ones);
        if (op == OP_INSTR || op == OP_DATA)
            return lead_len(op) + body_len(op, ir_len, dr_len, ones) + 2;
        return ones + 1;
    endfunction

    function automatic jtm_step_t decode_step(jtm_op_e op, int step,
                                              int ir_len, int dr_len, int ones);
        jtm_step_t s;
        int lead;
        int body;
        lead   = lead_len(op);
        body   = body_len(op, ir_len, dr_len, ones);
        s      = '0;
        s.last = (step == step_count(op, ir_len, dr_len, ones) - 1);
        if (op == OP_INSTR || op == OP_DATA) begin
            if (step < lead) begin
                // data path: 1,0,0 ; instruction path: 1,1,0,0
                s.tms = (op == OP_INSTR) ? (step < 2) : (step == 0);
            end else if (step < lead + body) begin
                s.shift = 1'b1;
                s.tms   = (step == lead + body - 1);
            end else begin
                // exit -> update with 1, update -> idle with 0
                s.tms = (step == lead + body);
            end
        end else begin
            s.tms = (step < ones);
        end
        return s;
    endfunction

endpackage

// File: rtl/jtm_tck_div.sv
module jtm_tck_div #(
    parameter int HALF_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              run,
    input  logic [HALF_W-1:0] half_in,
    output logic              tck,
    output logic              rise_stb,
    output logic              fall_stb
);
    localparam int CW = HALF_W + 1;

    logic [HALF_W-1:0] half_q;
    logic [HALF_W-1:0] cnt_q;
    logic [CW-1:0]     limit;
    logic [CW-1:0]     cnt_nx;
    logic              at_edge;

    always_ff @(posedge clk) begin
        if (rst)
            half_q <= HALF_W'(1);
        else if (start)
            half_q <= half_in;
    end

    assign limit   = (half_q == '0) ? CW'(1) : {1'b0, half_q};
    assign cnt_nx  = {1'b0, cnt_q} + CW'(1);
    assign at_edge = run && (cnt_nx == limit);

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt_q <= '0;
            tck   <= 1'b0;
        end else if (at_edge) begin
            cnt_q <= '0;
            tck   <= ~tck;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign rise_stb = at_edge && !tck;
    assign fall_stb = at_edge && tck;

endmodule

// File: rtl/jtm_step_ctrl.sv
module jtm_step_ctrl
    import jtm_pkg::*;
#(
    parameter int IR_LEN     = 5,
    parameter int DR_LEN     = 32,
    parameter int RESET_ONES = 5,
    parameter int STEP_W     = 6,
    parameter int IDX_W      = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  jtm_op_e          op_in,
    input  logic             fall_stb,
    output logic             busy,
    output logic             done,
    output logic             tms,
    output logic             shift_now,
    output logic [IDX_W-1:0] shift_idx
);
    jtm_op_e           op_q;
    logic [STEP_W-1:0] step_q;
    jtm_step_t         cur;

    assign cur = decode_step(op_q, int'(step_q), IR_LEN, DR_LEN, RESET_ONES);

    always_ff @(posedge clk) begin
        if (rst) begin
            op_q   <= OP_TAP_RESET;
            step_q <= '0;
            busy   <= 1'b0;
            done   <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start) begin
                op_q   <= op_in;
                step_q <= '0;
                busy   <= 1'b1;
            end else if (busy && fall_stb) begin
                if (cur.last) begin
                    busy   <= 1'b0;
                    done   <= 1'b1;
                    step_q <= '0;
                end else begin
                    step_q <= step_q + 1'b1;
                end
            end
        end
    end

    // Outputs follow the step register, which only moves on a falling test clock
    assign tms       = busy & cur.tms;
    assign shift_now = busy & cur.shift;
    assign shift_idx = IDX_W'(int'(step_q) - lead_len(op_q));

endmodule

// File: rtl/jtm_shift_path.sv
module jtm_shift_path #(
    parameter int DR_LEN = 32,
    parameter int IDX_W  = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [DR_LEN-1:0] wdata_in,
    input  logic              rise_stb,
    input  logic              shift_now,
    input  logic [IDX_W-1:0]  shift_idx,
    input  logic              tdo,
    output logic              tdi,
    output logic [DR_LEN-1:0] rdata
);
    logic [DR_LEN-1:0] wdata_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            wdata_q <= '0;
            rdata   <= '0;
        end else if (start) begin
            wdata_q <= wdata_in;
            rdata   <= '0;
        end else if (rise_stb && shift_now) begin
            rdata[shift_idx] <= tdo;
        end
    end

    assign tdi = shift_now & wdata_q[shift_idx];

endmodule

// File: rtl/jtag_scan_master.sv
module jtag_scan_master
    import jtm_pkg::*;
#(
    parameter int IR_LEN     = 5,
    parameter int DR_LEN     = 32,
    parameter int HALF_W     = 4,
    parameter int RESET_ONES = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [HALF_W-1:0] half_period,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic [1:0]        cmd_op,
    input  logic [DR_LEN-1:0] cmd_wdata,
    output logic              rsp_valid,
    output logic [DR_LEN-1:0] rsp_rdata,
    output logic              busy,
    output logic              tck,
    output logic              tms,
    output logic              tdi,
    input  logic              tdo
);
    localparam int STEP_W = $clog2(IR_LEN + DR_LEN + RESET_ONES + 8);
    localparam int IDX_W  = $clog2(DR_LEN);

    logic             start;
    logic             rise_stb;
    logic             fall_stb;
    logic             shift_now;
    logic [IDX_W-1:0] shift_idx;

    assign cmd_ready = !busy;
    assign start     = cmd_valid && cmd_ready;

    jtm_tck_div #(
        .HALF_W (HALF_W)
    ) u_div (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .run      (busy),
        .half_in  (half_period),
        .tck      (tck),
        .rise_stb (rise_stb),
        .fall_stb (fall_stb)
    );

    jtm_step_ctrl #(
        .IR_LEN     (IR_LEN),
        .DR_LEN     (DR_LEN),
        .RESET_ONES (RESET_ONES),
        .STEP_W     (STEP_W),
        .IDX_W      (IDX_W)
    ) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .op_in     (jtm_op_e'(cmd_op)),
        .fall_stb  (fall_stb),
        .busy      (busy),
        .done      (rsp_valid),
        .tms       (tms),
        .shift_now (shift_now),
        .shift_idx (shift_idx)
    );

    jtm_shift_path #(
        .DR_LEN (DR_LEN),
        .IDX_W  (IDX_W)
    ) u_path (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .wdata_in  (cmd_wdata),
        .rise_stb  (rise_stb),
        .shift_now (shift_now),
        .shift_idx (shift_idx),
        .tdo       (tdo),
        .tdi       (tdi),
        .rdata     (rsp_rdata)
    );

endmodule

// File: rtl/jtm_checker.sv
module jtm_checker (
    input logic clk,
    input logic rst,
    input logic cmd_valid,
    input logic cmd_ready,
    input logic busy,
    input logic rsp_valid,
    input logic tck,
    input logic tms,
    input logic tdi
);
    // R2: test clock rests low outside a command
    a_r2_tck_low_when_idle: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !tck);

    // R3: pins hold steady through the high phase
    a_r3_pins_steady_high: assert property (@(posedge clk) disable iff (rst)
        tck |-> ($stable(tms) && $stable(tdi)));

    // R9: handshake and completion
    a_r9_not_ready_busy: assert property (@(posedge clk) disable iff (rst)
        busy |-> !cmd_ready);

    a_r9_accept_sets_busy: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_ready) |=> busy);

    a_r9_done_single: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> !rsp_valid);

    a_r9_busy_ends_with_done: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> rsp_valid);

    a_r9_done_not_busy: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> !busy);

    // R5: every walk ends with mode select low (parked in Run-Test/Idle)
    a_r5_parked_on_done: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> (!tms && !tck));

endmodule

bind jtag_scan_master jtm_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .cmd_valid (cmd_valid),
    .cmd_ready (cmd_ready),
    .busy      (busy),
    .rsp_valid (rsp_valid),
    .tck       (tck),
    .tms       (tms),
    .tdi       (tdi)
);

// File: tb/tb_jtag_scan_master.sv
module tb_jtag_scan_master;
    localparam int CLK_PERIOD = 10;
    localparam int IRL = 5;
    localparam int DRL = 32;
    localparam int HW  = 4;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic [HW-1:0]  half_period = '0;
    logic           cmd_valid = 1'b0;
    logic           cmd_ready;
    logic [1:0]     cmd_op = '0;
    logic [DRL-1:0] cmd_wdata = '0;
    logic           rsp_valid;
    logic [DRL-1:0] rsp_rdata;
    logic           busy;
    logic           tck;
    logic           tms;
    logic           tdi;
    logic           tdo = 1'b0;

    int n_run  = 0;
    int n_fail = 0;
    bit finished = 0;
    int unsigned cyc = 0;

    jtag_scan_master #(.IR_LEN(IRL), .DR_LEN(DRL), .HALF_W(HW), .RESET_ONES(5)) dut (
        .clk(clk), .rst(rst), .half_period(half_period), .cmd_valid(cmd_valid),
        .cmd_ready(cmd_ready), .cmd_op(cmd_op), .cmd_wdata(cmd_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .busy(busy),
        .tck(tck), .tms(tms), .tdi(tdi), .tdo(tdo)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // Behavioural access-port model on the pins
    typedef enum int {
        S_TLR, S_RTI, S_SELDR, S_CAPDR, S_SHDR, S_EX1DR, S_PADR, S_EX2DR, S_UPDR,
        S_SELIR, S_CAPIR, S_SHIR, S_EX1IR, S_PAIR, S_EX2IR, S_UPIR
    } tap_e;

    tap_e           ts = S_PADR;
    logic [DRL-1:0] t_dr = 32'hC0DE_0001;
    logic [DRL-1:0] t_sr = '0;
    logic [IRL-1:0] t_ir = 5'b00110;
    logic [IRL-1:0] t_irs = '0;
    logic [63:0]    tms_vec = '0;
    logic [63:0]    tdi_vec = '0;
    int             nrise = 0;

    function automatic tap_e tap_next(tap_e s, logic m);
        case (s)
            S_TLR:   return m ? S_TLR   : S_RTI;
            S_RTI:   return m ? S_SELDR : S_RTI;
            S_SELDR: return m ? S_SELIR : S_CAPDR;
            S_CAPDR: return m ? S_EX1DR : S_SHDR;
            S_SHDR:  return m ? S_EX1DR : S_SHDR;
            S_EX1DR: return m ? S_UPDR  : S_PADR;
            S_PADR:  return m ? S_EX2DR : S_PADR;
            S_EX2DR: return m ? S_UPDR  : S_SHDR;
            S_UPDR:  return m ? S_SELDR : S_RTI;
            S_SELIR: return m ? S_TLR   : S_CAPIR;
            S_CAPIR: return m ? S_EX1IR : S_SHIR;
            S_SHIR:  return m ? S_EX1IR : S_SHIR;
            S_EX1IR: return m ? S_UPIR  : S_PAIR;
            S_PAIR:  return m ? S_EX2IR : S_PAIR;
            S_EX2IR: return m ? S_UPIR  : S_SHIR;
            default: return m ? S_SELDR : S_RTI;
        endcase
    endfunction

    always @(posedge tck) begin
        if (nrise < 64) begin
            tms_vec[nrise] = tms;
            tdi_vec[nrise] = tdi;
        end
        nrise = nrise + 1;
        case (ts)
            S_TLR:   t_ir  = 5'b00001;
            S_CAPDR: t_sr  = t_dr;
            S_SHDR:  t_sr  = {tdi, t_sr[DRL-1:1]};
            S_UPDR:  t_dr  = t_sr;
            S_CAPIR: t_irs = t_ir;
            S_SHIR:  t_irs = {tdi, t_irs[IRL-1:1]};
            S_UPIR:  t_ir  = t_irs;
            default: ;
        endcase
        ts = tap_next(ts, tms);
    end

    always @(negedge tck) begin
        if (ts == S_SHDR)      tdo = t_sr[0];
        else if (ts == S_SHIR) tdo = t_irs[0];
        else                   tdo = 1'b0;
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic int exp_total(int op);
        if (op == 1) return 11;
        if (op == 2) return 37;
        return 6;
    endfunction

    function automatic logic [63:0] exp_tms_vec(int op);
        logic [63:0] v;
        v = '0;
        if (op == 1) begin
            v[0] = 1; v[1] = 1; v[8] = 1; v[9] = 1;   // 1,1,0,0, 4x0,1, 1,0
        end else if (op == 2) begin
            v[0] = 1; v[34] = 1; v[35] = 1;          // 1,0,0, 31x0,1, 1,0
        end else begin
            v[4:0] = 5'b11111;
        end
        return v;
    endfunction

    task automatic run_cmd(input int op, input logic [31:0] wd, input int half, input bit poke);
        int h, tot, a, lat, guard, lead, len, keep_rise;
        logic [31:0] old_dr, exp_rd, exp_tdi, got_tdi, dr_after;
        logic [4:0]  old_ir;
        string req;
        h   = (half == 0) ? 1 : half;
        tot = exp_total(op);
        req = (op == 1) ? "R6" : (op == 2) ? "R5" : "R4";
        @(negedge clk);
        while (!cmd_ready) @(negedge clk);
        old_dr = t_dr; old_ir = t_ir;
        nrise = 0; tms_vec = '0; tdi_vec = '0;
        cmd_valid = 1'b1; cmd_op = op[1:0]; cmd_wdata = wd; half_period = half[HW-1:0];
        @(negedge clk);
        a = int'(cyc);
        cmd_valid = 1'b0;
        check(busy === 1'b1 && cmd_ready === 1'b0, "R9", "busy after accept",
              {62'b0, busy, cmd_ready}, 64'h2);
        if (poke) begin
            for (int i = 0; i < 3; i++) begin
                cmd_valid = 1'b1; cmd_op = 2'd2; cmd_wdata = ~wd;
                check(cmd_ready === 1'b0, "R9", "ready while busy", {63'b0, cmd_ready}, 64'h0);
                @(negedge clk);
            end
            cmd_valid = 1'b0;
        end
        guard = 0;
        while (rsp_valid !== 1'b1 && guard < 20000) begin
            @(negedge clk);
            guard++;
        end
        lat = int'(cyc) - a;
        check(lat == 2 * h * tot, "R10", "latency", 64'(lat), 64'(2 * h * tot));
        check(busy === 1'b0, "R9", "busy at done", {63'b0, busy}, 64'h0);
        check(nrise == tot, req, "tck rising count", 64'(nrise), 64'(tot));
        check(tms_vec == exp_tms_vec(op), req, "tms sequence", tms_vec, exp_tms_vec(op));
        check(ts == S_RTI, req, "target parked in idle", 64'(ts), 64'(S_RTI));
        check(tck === 1'b0, "R2", "tck low at done", {63'b0, tck}, 64'h0);
        if (op == 1 || op == 2) begin
            lead = (op == 1) ? 4 : 3;
            len  = (op == 1) ? IRL : DRL;
            exp_tdi = '0; got_tdi = '0;
            for (int k = 0; k < len; k++) begin
                exp_tdi[k] = wd[k];
                got_tdi[k] = tdi_vec[lead + k];
            end
            check(got_tdi == exp_tdi, "R7", "tdi bits lsb first", 64'(got_tdi), 64'(exp_tdi));
        end
        if (op == 1) begin
            exp_rd = {27'b0, old_ir};
            check(t_ir == wd[4:0], "R7", "instruction register", 64'(t_ir), 64'(wd[4:0]));
            check(t_dr == old_dr, "R7", "data register untouched", 64'(t_dr), 64'(old_dr));
        end else if (op == 2) begin
            exp_rd = old_dr;
            check(t_dr == wd, "R7", "data register", 64'(t_dr), 64'(wd));
        end else begin
            exp_rd = '0;
            check(t_ir == 5'b00001, "R4", "reset instruction", 64'(t_ir), 64'h1);
        end
        check(rsp_rdata == exp_rd, "R8", "captured word", 64'(rsp_rdata), 64'(exp_rd));
        if (poke) begin
            keep_rise = nrise;
            dr_after = t_dr;
            for (int i = 0; i < 20; i++) begin
                @(negedge clk);
                if (rsp_valid !== 1'b0 || busy !== 1'b0)
                    check(1'b0, "R9", "ignored command started", {62'b0, rsp_valid, busy}, 64'h0);
            end
            check(nrise == keep_rise, "R9", "no extra tck edges", 64'(nrise), 64'(keep_rise));
            check(t_dr == dr_after, "R9", "ignored write had no effect", 64'(t_dr), 64'(dr_after));
        end
        @(negedge clk);
        check(rsp_valid === 1'b0, "R9", "done is one cycle", {63'b0, rsp_valid}, 64'h0);
    endtask

    task automatic check_phases(input int half);
        int h, lo, hi;
        h = (half == 0) ? 1 : half;
        @(negedge clk);
        while (!cmd_ready) @(negedge clk);
        cmd_valid = 1'b1; cmd_op = 2'd0; half_period = half[HW-1:0];
        @(negedge clk);
        cmd_valid = 1'b0;
        lo = 1;
        while (tck === 1'b0) begin @(negedge clk); if (tck === 1'b0) lo++; end
        hi = 0;
        while (tck === 1'b1) begin hi++; @(negedge clk); end
        check(lo == h, "R2", "low phase length", 64'(lo), 64'(h));
        check(hi == h, "R2", "high phase length", 64'(hi), 64'(h));
        while (rsp_valid !== 1'b1) @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 190000);
        if (!finished) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        int op, half;
        logic [31:0] wd;
        void'($urandom(32'd2718));
        repeat (4) @(negedge clk);
        check(tck === 1'b0 && tms === 1'b0 && tdi === 1'b0 && busy === 1'b0 &&
              rsp_valid === 1'b0 && cmd_ready === 1'b1, "R1", "pins during reset",
              {58'b0, tck, tms, tdi, busy, rsp_valid, cmd_ready}, 64'h1);
        rst = 1'b0;
        @(negedge clk);
        check(tck === 1'b0 && tms === 1'b0 && busy === 1'b0 && cmd_ready === 1'b1,
              "R1", "pins after reset", {60'b0, tck, tms, busy, cmd_ready}, 64'h1);

        // directed corners
        run_cmd(0, 32'h0, 3, 0);              // recover from pause state
        run_cmd(2, 32'hFFFF_FFFF, 0, 0);      // half 0 acts as 1
        run_cmd(2, 32'h0000_0000, 1, 0);
        run_cmd(2, 32'hA5C3_0F81, 15, 0);
        run_cmd(1, 32'hFFFF_FFF5, 2, 0);
        run_cmd(1, 32'h0000_000A, 1, 0);
        run_cmd(3, 32'h1234_5678, 2, 0);      // alias of reset
        run_cmd(2, 32'h8000_0001, 4, 1);      // offered command while busy
        check_phases(0);
        check_phases(1);
        check_phases(7);
        check_phases(15);

        // random mix
        for (int n = 0; n < 30; n++) begin
            op   = int'($urandom_range(0, 3));
            half = int'($urandom_range(0, 15));
            wd   = $urandom;
            run_cmd(op, wd, half, (n % 7) == 3);
        end

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule